// File: doc/BRIEF.md
# Indirect Interrupt-Register Access Window

This block gives a hart a narrow window onto a large set of interrupt-control registers. Software first writes an index into a select register, then reads or writes a paired data CSR. The block then resolves that index to a target. There are three select/data pairs: machine, supervisor and virtual supervisor. When the hart runs virtualized, the supervisor pair is silently steered to the virtual-supervisor pair.

Each CSR access arrives as a single-cycle request: CSR number, write data and write mask. Read data and a fault code come back in the same cycle. Select registers update at the next clock edge. A data access is routed by the current select value. Values in the local priority range go to a priority-array port. Values in the interrupt-file range go to an external interrupt-file port, which also carries privilege, guest index and register width. Any other value faults. The priority storage and the interrupt files sit outside this block.

Top module: `csr_indirect_window`

## Requirements
- R1: Three independent 9-bit select registers exist, one each for machine (select CSR 0x350, data CSR 0x351), supervisor (0x150 / 0x151) and virtual supervisor (0x250 / 0x251). All reset to zero, and a select CSR read returns its register zero-extended.
- R2: A select write applies new = (old & ~m) | (wdata & m), where m is the write mask cut down to bits 8:0. A read returns the old value in the access cycle, and the new value is visible from the next cycle. When m is zero, the register keeps its value.
- R3: While `virt_on` is 1, CSR numbers 0x150 and 0x151 act on the virtual-supervisor select register and window.
- R4: A data access whose select value lies in 0x30..0x3F raises `prio_req` and drives `prio_isel`. It also drives `prio_level`: 0 for machine, 1 for supervisor. The access returns `prio_rdata`. `prio_req` and `file_req` are never both high.
- R5: With XLEN = 64, an odd select value in 0x30..0x3F faults and raises no request.
- R6: A virtual-supervisor data access with a select value in 0x30..0x3F faults and raises no request.
- R7: A data access whose select value lies in 0x70..0xFF raises `file_req` only if a file is present for its privilege. Machine uses `file_present_m`. Supervisor and virtual supervisor use `file_present_s`. With `file_req` high, the block drives `file_isel`, `file_priv_m` (1 = machine), `file_virt`, `file_guest` (0 unless virtual) and `file_xlen` (2 = 64-bit, 1 = 32-bit), and returns `file_rdata`. With no file present, the access faults.
- R8: A virtual-supervisor access in 0x70..0xFF faults with no request when `guest_idx` is 0 or greater than GEILEN (default 15).
- R9: A data access faults when its select value is outside both ranges, including 0x100..0x1FF. It also faults when `file_err` is high with `file_req`. A faulting access returns read data 0.
- R10: Fault codes are 0 none, 1 illegal, 2 virtual. A data fault is coded 2 only when `virt_on` is 1 and the access targets the virtual-supervisor window. Every other fault, and any CSR number not listed in R1, is coded 1.
- R11: With `csr_valid` low, the fault code is 0, read data is 0, no request is raised, and no select register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | CSR access this cycle |
| csr_num | input | 12 | CSR number |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Write mask (zero for a pure read) |
| virt_on | input | 1 | Hart is in virtualized mode |
| guest_idx | input | GUEST_W | Guest interrupt-file index from hypervisor status |
| file_present_m | input | 1 | Machine-level interrupt file exists |
| file_present_s | input | 1 | Supervisor-level interrupt file exists |
| csr_rdata | output | XLEN | Read data |
| csr_fault | output | 2 | Fault code |
| prio_req | output | 1 | Priority-array access |
| prio_level | output | 1 | 0 machine, 1 supervisor |
| prio_isel | output | SEL_W | Select value for priority array |
| prio_wdata | output | XLEN | Write data to priority array |
| prio_wmask | output | XLEN | Write mask to priority array |
| prio_rdata | input | XLEN | Priority-array read data |
| file_req | output | 1 | Interrupt-file access |
| file_isel | output | SEL_W | Select value for interrupt file |
| file_priv_m | output | 1 | 1 machine, 0 supervisor |
| file_virt | output | 1 | Access from virtual-supervisor window |
| file_guest | output | GUEST_W | Guest file index (0 when not virtual) |
| file_xlen | output | 2 | Register width code |
| file_wdata | output | XLEN | Write data to interrupt file |
| file_wmask | output | XLEN | Write mask to interrupt file |
| file_rdata | input | XLEN | Interrupt-file read data |
| file_err | input | 1 | Interrupt file rejects the access |

## Verification
The properties assume that every input holds steady between clock edges. They also assume that `file_err` is only taken into account while `file_req` is high. On that basis, a high `file_err` with no request must not produce a fault. The bench drives all inputs at the falling edge. It keeps `guest_idx` within its 6-bit field, with a bias around 0 and GEILEN. It keeps CSR numbers to the six window CSRs plus one unlisted number. Select values are biased toward both routing ranges and their edges.

// File: rtl/csr_win_pkg.sv
package csr_win_pkg;

    localparam int CSR_NUM_W = 12;
    localparam int NUM_LVL   = 3;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ILLEGAL = 2'd1,
        FLT_VIRT    = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        LVL_M  = 2'd0,
        LVL_S  = 2'd1,
        LVL_VS = 2'd2
    } level_e;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_PRIO  = 2'd1,
        RT_FILE  = 2'd2,
        RT_FAULT = 2'd3
    } route_e;

    localparam logic [CSR_NUM_W-1:0] CSRN_M_SEL   = 12'h350;
    localparam logic [CSR_NUM_W-1:0] CSRN_M_DATA  = 12'h351;
    localparam logic [CSR_NUM_W-1:0] CSRN_S_SEL   = 12'h150;
    localparam logic [CSR_NUM_W-1:0] CSRN_S_DATA  = 12'h151;
    localparam logic [CSR_NUM_W-1:0] CSRN_VS_SEL  = 12'h250;
    localparam logic [CSR_NUM_W-1:0] CSRN_VS_DATA = 12'h251;

endpackage

// File: rtl/csr_win_decode.sv
module csr_win_decode
    import csr_win_pkg::*;
(
    input  logic [CSR_NUM_W-1:0] csr_num,
    input  logic                 virt_on,
    output logic                 hit,
    output logic                 is_sel,
    output level_e               level,
    output logic                 vwin
);

    always_comb begin
        hit    = 1'b1;
        is_sel = 1'b0;
        level  = LVL_M;
        unique case (csr_num)
            CSRN_M_SEL: begin
                is_sel = 1'b1;
                level  = LVL_M;
            end
            CSRN_M_DATA: begin
                level  = LVL_M;
            end
            CSRN_S_SEL: begin
                is_sel = 1'b1;
                level  = virt_on ? LVL_VS : LVL_S;
            end
            CSRN_S_DATA: begin
                level  = virt_on ? LVL_VS : LVL_S;
            end
            CSRN_VS_SEL: begin
                is_sel = 1'b1;
                level  = LVL_VS;
            end
            CSRN_VS_DATA: begin
                level  = LVL_VS;
            end
            default: begin
                hit    = 1'b0;
            end
        endcase
        vwin = hit && (level == LVL_VS);
    end

endmodule

// File: rtl/csr_win_sel_bank.sv
module csr_win_sel_bank
    import csr_win_pkg::*;
#(
    parameter int SEL_W = 9
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  level_e                           wr_level,
    input  logic [SEL_W-1:0]                 wdata,
    input  logic [SEL_W-1:0]                 wmask,
    output logic [NUM_LVL-1:0][SEL_W-1:0]    sel_q
);

    typedef struct packed {
        logic [NUM_LVL-1:0][SEL_W-1:0] sel;
    } bank_t;

    bank_t st_d, st_q;

    logic [NUM_LVL-1:0][SEL_W-1:0] merged;
    logic [NUM_LVL-1:0]            upd;

    for (genvar lv = 0; lv < NUM_LVL; lv++) begin : g_lvl
        assign merged[lv] = (st_q.sel[lv] & ~wmask) | (wdata & wmask);
        assign upd[lv]    = wr_en && (wr_level == 2'(lv)) && (|wmask);
    end

    always_comb begin
        st_d = st_q;
        for (int lv = 0; lv < NUM_LVL; lv++) begin
            if (upd[lv]) begin
                st_d.sel[lv] = merged[lv];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_q = st_q.sel;

endmodule

// File: rtl/csr_win_route.sv
module csr_win_route
    import csr_win_pkg::*;
#(
    parameter int          SEL_W   = 9,
    parameter int          XLEN    = 64,
    parameter int          GUEST_W = 6,
    parameter int          GEILEN  = 15,
    parameter logic [8:0]  PRIO_LO = 9'h030,
    parameter logic [8:0]  PRIO_HI = 9'h03F,
    parameter logic [8:0]  FILE_LO = 9'h070,
    parameter logic [8:0]  FILE_HI = 9'h0FF
) (
    input  logic               access,
    input  level_e             level,
    input  logic [SEL_W-1:0]   isel,
    input  logic [GUEST_W-1:0] guest_idx,
    input  logic               file_present_m,
    input  logic               file_present_s,
    input  logic [XLEN-1:0]    prio_rdata,
    input  logic [XLEN-1:0]    file_rdata,
    input  logic               file_err,
    output logic               prio_req,
    output logic               file_req,
    output logic               data_fault,
    output logic [XLEN-1:0]    data_rdata
);

    localparam logic [GUEST_W-1:0] GUEST_MAX = GUEST_W'(GEILEN);
    localparam bit                 WIDE      = (XLEN == 64);

    logic   in_prio, in_file, present, guest_bad;
    route_e route;

    assign in_prio   = (isel >= SEL_W'(PRIO_LO)) && (isel <= SEL_W'(PRIO_HI));
    assign in_file   = (isel >= SEL_W'(FILE_LO)) && (isel <= SEL_W'(FILE_HI));
    assign present   = (level == LVL_M) ? file_present_m : file_present_s;
    assign guest_bad = (guest_idx == '0) || (guest_idx > GUEST_MAX);

    always_comb begin
        route = RT_NONE;
        if (access) begin
            if (in_prio) begin
                if (level == LVL_VS) begin
                    route = RT_FAULT;
                end else if (WIDE && isel[0]) begin
                    route = RT_FAULT;
                end else begin
                    route = RT_PRIO;
                end
            end else if (in_file) begin
                if (!present) begin
                    route = RT_FAULT;
                end else if ((level == LVL_VS) && guest_bad) begin
                    route = RT_FAULT;
                end else begin
                    route = RT_FILE;
                end
            end else begin
                route = RT_FAULT;
            end
        end
    end

    always_comb begin
        prio_req   = (route == RT_PRIO);
        file_req   = (route == RT_FILE);
        data_fault = (route == RT_FAULT) || (file_req && file_err);
        data_rdata = '0;
        if (prio_req) begin
            data_rdata = prio_rdata;
        end else if (file_req && !file_err) begin
            data_rdata = file_rdata;
        end
    end

endmodule

// File: rtl/csr_indirect_window.sv
module csr_indirect_window
    import csr_win_pkg::*;
#(
    parameter int SEL_W   = 9,
    parameter int XLEN    = 64,
    parameter int GUEST_W = 6,
    parameter int GEILEN  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_valid,
    input  logic [11:0]          csr_num,
    input  logic [XLEN-1:0]      csr_wdata,
    input  logic [XLEN-1:0]      csr_wmask,
    input  logic                 virt_on,
    input  logic [GUEST_W-1:0]   guest_idx,
    input  logic                 file_present_m,
    input  logic                 file_present_s,
    output logic [XLEN-1:0]      csr_rdata,
    output logic [1:0]           csr_fault,
    output logic                 prio_req,
    output logic                 prio_level,
    output logic [SEL_W-1:0]     prio_isel,
    output logic [XLEN-1:0]      prio_wdata,
    output logic [XLEN-1:0]      prio_wmask,
    input  logic [XLEN-1:0]      prio_rdata,
    output logic                 file_req,
    output logic [SEL_W-1:0]     file_isel,
    output logic                 file_priv_m,
    output logic                 file_virt,
    output logic [GUEST_W-1:0]   file_guest,
    output logic [1:0]           file_xlen,
    output logic [XLEN-1:0]      file_wdata,
    output logic [XLEN-1:0]      file_wmask,
    input  logic [XLEN-1:0]      file_rdata,
    input  logic                 file_err
);

    localparam logic [1:0] XLEN_CODE = (XLEN == 64) ? 2'd2 : 2'd1;

    logic                          hit, is_sel, vwin;
    level_e                        level;
    logic [NUM_LVL-1:0][SEL_W-1:0] sel_q;
    logic [SEL_W-1:0]              isel;
    logic                          data_fault;
    logic [XLEN-1:0]               data_rdata;
    logic                          sel_wr, data_acc;

    csr_win_decode i_decode (
        .csr_num (csr_num),
        .virt_on (virt_on),
        .hit     (hit),
        .is_sel  (is_sel),
        .level   (level),
        .vwin    (vwin)
    );

    assign sel_wr   = csr_valid && hit && is_sel;
    assign data_acc = csr_valid && hit && !is_sel;

    csr_win_sel_bank #(.SEL_W(SEL_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (sel_wr),
        .wr_level (level),
        .wdata    (csr_wdata[SEL_W-1:0]),
        .wmask    (csr_wmask[SEL_W-1:0]),
        .sel_q    (sel_q)
    );

    assign isel = sel_q[level];

    csr_win_route #(
        .SEL_W   (SEL_W),
        .XLEN    (XLEN),
        .GUEST_W (GUEST_W),
        .GEILEN  (GEILEN)
    ) i_route (
        .access         (data_acc),
        .level          (level),
        .isel           (isel),
        .guest_idx      (guest_idx),
        .file_present_m (file_present_m),
        .file_present_s (file_present_s),
        .prio_rdata     (prio_rdata),
        .file_rdata     (file_rdata),
        .file_err       (file_err),
        .prio_req       (prio_req),
        .file_req       (file_req),
        .data_fault     (data_fault),
        .data_rdata     (data_rdata)
    );

    always_comb begin
        csr_fault = FLT_NONE;
        csr_rdata = '0;
        if (csr_valid) begin
            if (!hit) begin
                csr_fault = FLT_ILLEGAL;
            end else if (is_sel) begin
                csr_rdata = XLEN'(isel);
            end else if (data_fault) begin
                csr_fault = (virt_on && vwin) ? FLT_VIRT : FLT_ILLEGAL;
            end else begin
                csr_rdata = data_rdata;
            end
        end
    end

    assign prio_level  = (level != LVL_M);
    assign prio_isel   = isel;
    assign prio_wdata  = csr_wdata;
    assign prio_wmask  = csr_wmask;
    assign file_isel   = isel;
    assign file_priv_m = (level == LVL_M);
    assign file_virt   = (level == LVL_VS);
    assign file_guest  = (level == LVL_VS) ? guest_idx : '0;
    assign file_xlen   = XLEN_CODE;
    assign file_wdata  = csr_wdata;
    assign file_wmask  = csr_wmask;

endmodule

// File: rtl/csr_win_checker.sv
module csr_win_checker #(
    parameter int SEL_W   = 9,
    parameter int XLEN    = 64,
    parameter int GUEST_W = 6,
    parameter int GEILEN  = 15
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   csr_valid,
    input logic [11:0]            csr_num,
    input logic                   virt_on,
    input logic [1:0]             csr_fault,
    input logic [XLEN-1:0]        csr_rdata,
    input logic                   prio_req,
    input logic [SEL_W-1:0]       prio_isel,
    input logic                   file_req,
    input logic [SEL_W-1:0]       file_isel,
    input logic                   file_virt,
    input logic [GUEST_W-1:0]     file_guest,
    input logic                   file_err,
    input logic [3*SEL_W-1:0]     sel_q
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_valid |-> (csr_fault == 2'd0 && !prio_req && !file_req && csr_rdata == '0)); // R11

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_valid |=> $stable(sel_q)); // R2

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(prio_req && file_req)); // R4

    AST_PRIO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prio_req |-> (prio_isel >= SEL_W'(9'h030) && prio_isel <= SEL_W'(9'h03F))); // R4

    AST_PRIO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_req && XLEN == 64) |-> !prio_isel[0]); // R5

    AST_VS_NO_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && (csr_num == 12'h251 || (virt_on && csr_num == 12'h151))) |-> !prio_req); // R6

    AST_FILE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        file_req |-> (file_isel >= SEL_W'(9'h070) && file_isel <= SEL_W'(9'h0FF))); // R7

    AST_GUEST_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (file_req && file_virt) |-> (file_guest != '0 && file_guest <= GUEST_W'(GEILEN))); // R8

    AST_FILE_ERR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (file_req && file_err) |-> (csr_fault != 2'd0 && csr_rdata == '0)); // R9

    AST_VIRT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_fault == 2'd2) |-> virt_on); // R10

endmodule

bind csr_indirect_window csr_win_checker #(
    .SEL_W   (SEL_W),
    .XLEN    (XLEN),
    .GUEST_W (GUEST_W),
    .GEILEN  (GEILEN)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_valid  (csr_valid),
    .csr_num    (csr_num),
    .virt_on    (virt_on),
    .csr_fault  (csr_fault),
    .csr_rdata  (csr_rdata),
    .prio_req   (prio_req),
    .prio_isel  (prio_isel),
    .file_req   (file_req),
    .file_isel  (file_isel),
    .file_virt  (file_virt),
    .file_guest (file_guest),
    .file_err   (file_err),
    .sel_q      (sel_q)
);

// File: tb/test_csr_indirect_window.sv
module test_csr_indirect_window;

    localparam int GEILEN = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_valid = 1'b0;
    logic [11:0] csr_num = '0;
    logic [63:0] csr_wdata = '0, csr_wmask = '0;
    logic        virt_on = 1'b0;
    logic [5:0]  guest_idx = '0;
    logic        file_present_m = 1'b1, file_present_s = 1'b1;
    logic        file_err = 1'b0;
    logic [63:0] csr_rdata, prio_wdata, prio_wmask, file_wdata, file_wmask;
    logic [63:0] prio_rdata, file_rdata;
    logic [1:0]  csr_fault, file_xlen;
    logic        prio_req, prio_level, file_req, file_priv_m, file_virt;
    logic [8:0]  prio_isel, file_isel;
    logic [5:0]  file_guest;

    int checks = 0;
    int errors = 0;
    logic [8:0] m_sel [3];

    always #10 clk = ~clk;

    assign prio_rdata = {31'h0, prio_level, 23'h0, prio_isel};
    assign file_rdata = {32'hF11E0000, 2'b0, file_guest, file_priv_m, file_virt, 13'h0, file_isel};

    csr_indirect_window i_csr_indirect_window (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_num(csr_num),
        .csr_wdata(csr_wdata), .csr_wmask(csr_wmask), .virt_on(virt_on),
        .guest_idx(guest_idx), .file_present_m(file_present_m),
        .file_present_s(file_present_s), .csr_rdata(csr_rdata), .csr_fault(csr_fault),
        .prio_req(prio_req), .prio_level(prio_level), .prio_isel(prio_isel),
        .prio_wdata(prio_wdata), .prio_wmask(prio_wmask), .prio_rdata(prio_rdata),
        .file_req(file_req), .file_isel(file_isel), .file_priv_m(file_priv_m),
        .file_virt(file_virt), .file_guest(file_guest), .file_xlen(file_xlen),
        .file_wdata(file_wdata), .file_wmask(file_wmask), .file_rdata(file_rdata),
        .file_err(file_err)
    );

    task automatic compare(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One access: drive at the falling edge, check combinational outputs mid-phase,
    // then advance the model for the select write taken at the next rising edge.
    task automatic access(input logic [11:0] num, input logic v, input logic [63:0] wd,
                          input logic [63:0] wm, input logic [5:0] g, input logic pm,
                          input logic ps, input logic fe, input string force_tag);
        logic known, issel, pr, fr, flt;
        int lvl;
        logic [8:0]  is;
        logic [1:0]  ef;
        logic [63:0] rd;
        logic [28:0] ef_fields, af_fields;
        string tag;
        @(negedge clk);
        csr_valid = 1'b1; csr_num = num; virt_on = v; csr_wdata = wd; csr_wmask = wm;
        guest_idx = g; file_present_m = pm; file_present_s = ps; file_err = fe;
        #5;
        known = 1'b1; issel = 1'b0; lvl = 0;
        case (num)
            12'h350: begin issel = 1'b1; lvl = 0; end
            12'h351: lvl = 0;
            12'h150: begin issel = 1'b1; lvl = v ? 2 : 1; end
            12'h151: lvl = v ? 2 : 1;
            12'h250: begin issel = 1'b1; lvl = 2; end
            12'h251: lvl = 2;
            default: known = 1'b0;
        endcase
        pr = 1'b0; fr = 1'b0; flt = 1'b0; rd = '0; ef = 2'd0; ef_fields = '0;
        tag = "R10";
        if (!known) begin
            ef = 2'd1;
        end else if (issel) begin
            rd = {55'h0, m_sel[lvl]};
            tag = (v && num == 12'h150) ? "R3" : "R2";
        end else begin
            is = m_sel[lvl];
            if (is >= 9'h030 && is <= 9'h03F) begin
                if (lvl == 2) begin flt = 1'b1; tag = "R6"; end
                else if (is[0]) begin flt = 1'b1; tag = "R5"; end
                else begin
                    pr = 1'b1; tag = "R4";
                    rd = {31'h0, (lvl != 0), 23'h0, is};
                    ef_fields = {(lvl != 0), is, 19'h0};
                end
            end else if (is >= 9'h070 && is <= 9'h0FF) begin
                if (!((lvl == 0) ? pm : ps)) begin flt = 1'b1; tag = "R7"; end
                else if (lvl == 2 && (g == 0 || g > GEILEN)) begin flt = 1'b1; tag = "R8"; end
                else begin
                    fr = 1'b1; tag = "R7";
                    ef_fields = {1'b0, is, (lvl == 0), (lvl == 2), (lvl == 2) ? g : 6'd0, 2'd2};
                    if (fe) begin flt = 1'b1; tag = "R9"; end
                    else rd = {32'hF11E0000, 2'b0, (lvl == 2) ? g : 6'd0, (lvl == 0), (lvl == 2), 13'h0, is};
                end
            end else begin
                flt = 1'b1; tag = "R9";
            end
            if (flt) ef = (v && lvl == 2) ? 2'd2 : 2'd1;
        end
        if (force_tag != "") tag = force_tag;
        af_fields = prio_req ? {prio_level, prio_isel, 19'h0}
                  : file_req ? {1'b0, file_isel, file_priv_m, file_virt, file_guest, file_xlen} : 29'h0;
        compare(tag, {31'h0, csr_fault, prio_req, file_req, csr_rdata, af_fields},
                     {31'h0, ef, pr, fr, rd, ef_fields});
        if (known && issel) m_sel[lvl] = (m_sel[lvl] & ~wm[8:0]) | (wd[8:0] & wm[8:0]);
    endtask

    task automatic idle_check();
        @(negedge clk);
        csr_valid = 1'b0; csr_wmask = '1; csr_wdata = '1; file_err = 1'b1; virt_on = 1'b1;
        #5;
        compare("R11", {59'h0, csr_fault, prio_req, file_req, csr_rdata},
                       {59'h0, 2'd0, 1'b0, 1'b0, 64'h0});
        file_err = 1'b0;
    endtask

    task automatic wr(input logic [11:0] num, input logic v, input logic [8:0] val);
        access(num, v, {55'h0, val}, 64'h1FF, 6'd1, 1'b1, 1'b1, 1'b0, "");
    endtask

    initial begin
        for (int i = 0; i < 3; i++) m_sel[i] = '0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values and independence
        access(12'h350, 0, '1, '0, 0, 1, 1, 0, "R1");
        access(12'h150, 0, '1, '0, 0, 1, 1, 0, "R1");
        access(12'h250, 0, '1, '0, 0, 1, 1, 0, "R1");
        wr(12'h350, 0, 9'h035);
        wr(12'h150, 0, 9'h072);
        wr(12'h250, 0, 9'h03A);
        access(12'h350, 0, '0, '0, 0, 1, 1, 0, "R1");
        access(12'h150, 0, '0, '0, 0, 1, 1, 0, "R1");
        access(12'h250, 0, '0, '0, 0, 1, 1, 0, "R1");
        // R2: zero effective mask, partial mask
        access(12'h350, 0, 64'h1FF, 64'h0, 0, 1, 1, 0, "R2");
        access(12'h350, 0, '1, 64'hFFFF_FFFF_FFFF_FE00, 0, 1, 1, 0, "R2");
        access(12'h350, 0, '0, '0, 0, 1, 1, 0, "R2");
        access(12'h150, 0, 64'h0F0, 64'h00F, 0, 1, 1, 0, "R2");
        access(12'h150, 0, '0, '0, 0, 1, 1, 0, "R2");
        wr(12'h150, 0, 9'h072);
        // R3: redirection
        access(12'h150, 1, '0, '0, 0, 1, 1, 0, "R3");
        // R5 then R4
        access(12'h351, 0, '0, '0, 0, 1, 1, 0, "R5");
        wr(12'h350, 0, 9'h036);
        access(12'h351, 0, 64'h55, 64'hFF, 0, 1, 1, 0, "R4");
        wr(12'h150, 0, 9'h030);
        access(12'h151, 0, '0, '0, 0, 1, 1, 0, "R4");
        // R6 / R10: VS window in priority range
        access(12'h151, 1, '0, '0, 3, 1, 1, 0, "R6");
        access(12'h251, 0, '0, '0, 3, 1, 1, 0, "R10");
        // R7: file presence
        wr(12'h150, 0, 9'h072);
        access(12'h151, 0, '0, '0, 0, 1, 0, 0, "R7");
        access(12'h151, 0, '0, '0, 0, 1, 1, 0, "R7");
        wr(12'h350, 0, 9'h0FF);
        access(12'h351, 0, '0, '0, 0, 0, 1, 0, "R7");
        access(12'h351, 0, '0, '0, 0, 1, 0, 0, "R7");
        // R8: guest index bounds
        wr(12'h250, 0, 9'h080);
        access(12'h251, 1, '0, '0, 6'd0, 1, 1, 0, "R8");
        access(12'h251, 1, '0, '0, 6'd16, 1, 1, 0, "R8");
        access(12'h251, 1, '0, '0, 6'd15, 1, 1, 0, "R8");
        access(12'h251, 1, '0, '0, 6'd1, 1, 1, 0, "R8");
        // R9: out of range and file error
        access(12'h251, 1, '0, '0, 6'd2, 1, 1, 1, "R9");
        wr(12'h350, 0, 9'h100);
        access(12'h351, 0, '0, '0, 0, 1, 1, 0, "R9");
        wr(12'h350, 0, 9'h06F);
        access(12'h351, 0, '0, '0, 0, 1, 1, 0, "R9");
        // R10: unknown number
        access(12'h340, 1, '0, '0, 0, 1, 1, 0, "R10");
        // R11: idle, then confirm no select change
        idle_check();
        access(12'h350, 0, '0, '0, 0, 1, 1, 0, "R11");

        for (int n = 0; n < 3000; n++) begin
            logic [11:0] num;
            logic [63:0] wd, wm;
            int r;
            r = $urandom % 14;
            case (r)
                0, 6:  num = 12'h350;
                1, 7:  num = 12'h150;
                2, 8:  num = 12'h250;
                3, 9:  num = 12'h351;
                4, 10: num = 12'h151;
                5, 11: num = 12'h251;
                12:    num = 12'h340;
                default: num = 12'h251;
            endcase
            case ($urandom % 5)
                0: wd = 64'h30 + ($urandom % 16);
                1: wd = 64'h70 + ($urandom % 144);
                2: wd = {$urandom, $urandom};
                3: wd = 64'h2F + ($urandom % 3) * 64'h20;
                default: wd = 64'h6F + ($urandom % 2) * 64'h91;
            endcase
            case ($urandom % 4)
                0: wm = '0;
                1: wm = '1;
                default: wm = {$urandom, $urandom};
            endcase
            if ($urandom % 6 == 0) idle_check();
            access(num, 1'($urandom), wd, wm, 6'($urandom % 18),
                   ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 8) == 0, "");
        end

        @(negedge clk) csr_valid = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule